// File: doc/BRIEF.md
# Decimal Adjust Unit

This block corrects the result of a binary add, subtract, multiply or pending divide so that a 16-bit accumulator pair (high byte and low byte) holds valid decimal digits again. It handles unpacked decimal, with one digit per byte, and packed decimal, with two digits per byte. It also has two base-conversion operations. Split-after-multiply divides the accumulator by an 8-bit base. Fold-before-divide turns a two-digit high:low pair into one binary byte. The correction logic itself is combinational. It sits behind a single registered output stage so that it fits into a streaming datapath.

Each request carries an opcode, the accumulator value, the incoming carry and auxiliary-carry flags, and an 8-bit base. A request is taken when `in_valid` and `in_ready` are both high at a rising clock edge. The result appears on the output one cycle later with `out_valid` high. Back-pressure works as follows. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the result stays frozen and no new request is taken. Results are only defined for operands that already hold decimal digits. For other operands the bench still predicts the exact outputs of the stated equations.

Top module: `decadj_unit`

## Requirements
- R1: Opcode 3'd0 (unpacked add adjust). If the low nibble of AL is above 9, or the incoming AF is 1: AX becomes AX+6 (16-bit), AH then gains 1 (mod 256), and CF and AF are both set. Otherwise CF and AF are both cleared. In either case AL[7:4] is forced to zero.
- R2: Opcode 3'd1 (unpacked subtract adjust). Under the same condition as R1: AL loses 6 (mod 256), AH loses 1 (mod 256), and CF and AF are set. Otherwise CF and AF are cleared. AL[7:4] is always forced to zero.
- R3: Opcode 3'd2 (packed add adjust) runs two steps. Step one: if the low nibble of AL is above 9 or AF is 1, AL gains 6 and AF is set. Step two works on the AL left by step one: if that AL is above 0x9F or CF is 1, AL gains 0x60 and CF is set. A flag that a step does not set keeps its incoming value. AH passes through unchanged.
- R4: Opcode 3'd3 (packed subtract adjust) works like R3, but subtracts 6 and 0x60 instead of adding them.
- R5: Opcode 3'd4 (split after multiply) with a non-zero base. AH becomes (AX div base) mod 256 and AL becomes AX mod base. CF and AF pass through unchanged.
- R6: Opcode 3'd4 with base 0 raises `out_fault` and passes AX, CF and AF through unchanged. `out_fault` is low for every other request.
- R7: Opcode 3'd5 (fold before divide). AL becomes (AH*base + AL) mod 256 and AH becomes 0. CF and AF pass through unchanged.
- R8: Opcodes 3'd6 and 3'd7 pass AX, CF and AF through unchanged and leave `out_fault` low.
- R9: A request taken at a clock edge appears on the outputs after that edge with `out_valid` high. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all result outputs hold their values.
- R10: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 3 | Operation code (see R1 to R8) |
| in_ax | input | 16 | Accumulator, AH in [15:8], AL in [7:0] |
| in_cf | input | 1 | Incoming carry flag |
| in_af | input | 1 | Incoming auxiliary carry flag |
| in_base | input | 8 | Base for split and fold operations |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_ax | output | 16 | Adjusted accumulator |
| out_cf | output | 1 | Resulting carry flag |
| out_af | output | 1 | Resulting auxiliary carry flag |
| out_fault | output | 1 | Zero base on split after multiply |

## Verification
The only state is the one-entry output register. A wrong value latched there shows up on `out_ax`, the flags or `out_fault` in the very cycle after the request is taken. It then stays visible until the consumer drains it. A wrong occupancy bit shows up at once as an `out_valid` or `in_ready` mismatch in that same cycle. It can also drop or duplicate a result, and the in-order expectation queue catches that at the next comparison. Random stalls on `out_ready` check that a held result does not drift, and the random opcode mix reaches the carry-into-AH and zero-base corners.

// File: rtl/decadj_pkg.sv
package decadj_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned AX_W   = 2 * BYTE_W;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned OP_W   = 3;

  localparam logic [BYTE_W-1:0] DIGIT_MAX = BYTE_W'(9);
  localparam logic [BYTE_W-1:0] LO_FIX    = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] HI_FIX    = BYTE_W'(8'h60);
  localparam logic [BYTE_W-1:0] HI_LIMIT  = BYTE_W'(8'h9F);

  typedef enum logic [OP_W-1:0] {
    OP_UNP_ADD   = 3'd0,
    OP_UNP_SUB   = 3'd1,
    OP_PK_ADD    = 3'd2,
    OP_PK_SUB    = 3'd3,
    OP_MUL_SPLIT = 3'd4,
    OP_DIV_FOLD  = 3'd5
  } op_e;

  typedef struct packed {
    logic [AX_W-1:0] ax;
    logic            cf;
    logic            af;
    logic            fault;
  } adj_res_t;
endpackage

// File: rtl/decadj_unpacked.sv
module decadj_unpacked
  import decadj_pkg::*;
#(
  parameter bit SUBTRACT = 1'b0
) (
  input  logic [AX_W-1:0] ax_i,
  input  logic            af_i,
  output logic [AX_W-1:0] ax_o,
  output logic            flag_o
);
  logic [BYTE_W-1:0] lo_digit;
  logic              need_fix;
  logic [BYTE_W-1:0] ah_fixed;
  logic [BYTE_W-1:0] al_fixed;

  assign lo_digit = {{(BYTE_W-NIB_W){1'b0}}, ax_i[NIB_W-1:0]};
  assign need_fix = (lo_digit > DIGIT_MAX) || af_i;

  generate
    if (SUBTRACT) begin : g_sub
      assign al_fixed = ax_i[BYTE_W-1:0] - LO_FIX;
      assign ah_fixed = ax_i[AX_W-1:BYTE_W] - BYTE_W'(1);
    end else begin : g_add
      logic [AX_W-1:0] wide_sum;
      assign wide_sum = ax_i + {{BYTE_W{1'b0}}, LO_FIX};
      assign al_fixed = wide_sum[BYTE_W-1:0];
      assign ah_fixed = wide_sum[AX_W-1:BYTE_W] + BYTE_W'(1);
    end
  endgenerate

  always_comb begin
    if (need_fix) begin
      ax_o = {ah_fixed, {(BYTE_W-NIB_W){1'b0}}, al_fixed[NIB_W-1:0]};
    end else begin
      ax_o = {ax_i[AX_W-1:BYTE_W], {(BYTE_W-NIB_W){1'b0}}, ax_i[NIB_W-1:0]};
    end
    flag_o = need_fix;
  end
endmodule

// File: rtl/decadj_packed.sv
module decadj_packed
  import decadj_pkg::*;
#(
  parameter bit SUBTRACT = 1'b0
) (
  input  logic [BYTE_W-1:0] al_i,
  input  logic              cf_i,
  input  logic              af_i,
  output logic [BYTE_W-1:0] al_o,
  output logic              cf_o,
  output logic              af_o
);
  logic [BYTE_W-1:0] lo_digit;
  logic              need_lo;
  logic              need_hi;
  logic [BYTE_W-1:0] al_mid;
  logic [BYTE_W-1:0] al_mid_fix;
  logic [BYTE_W-1:0] al_end_fix;

  assign lo_digit = {{(BYTE_W-NIB_W){1'b0}}, al_i[NIB_W-1:0]};
  assign need_lo  = (lo_digit > DIGIT_MAX) || af_i;

  generate
    if (SUBTRACT) begin : g_sub
      assign al_mid_fix = al_i - LO_FIX;
      assign al_end_fix = al_mid - HI_FIX;
    end else begin : g_add
      assign al_mid_fix = al_i + LO_FIX;
      assign al_end_fix = al_mid + HI_FIX;
    end
  endgenerate

  // step two examines the byte produced by step one
  assign al_mid  = need_lo ? al_mid_fix : al_i;
  assign need_hi = (al_mid > HI_LIMIT) || cf_i;

  assign al_o = need_hi ? al_end_fix : al_mid;
  assign af_o = need_lo ? 1'b1 : af_i;
  assign cf_o = need_hi ? 1'b1 : cf_i;
endmodule

// File: rtl/decadj_muldiv.sv
module decadj_muldiv
  import decadj_pkg::*;
(
  input  logic [AX_W-1:0]   ax_i,
  input  logic [BYTE_W-1:0] base_i,
  output logic [AX_W-1:0]   split_ax_o,
  output logic [AX_W-1:0]   fold_ax_o,
  output logic              zero_base_o
);
  localparam int unsigned TRIAL_W = BYTE_W + 1;

  logic [BYTE_W-1:0] rem_chain [AX_W+1];
  logic [AX_W-1:0]   quotient;

  assign rem_chain[0] = '0;

  // restoring division, one quotient bit per stage, MSB first
  generate
    for (genvar s = 0; s < AX_W; s++) begin : g_stage
      logic [TRIAL_W-1:0] trial;
      logic [TRIAL_W-1:0] diff;
      logic               fits;
      assign trial = {rem_chain[s], ax_i[AX_W-1-s]};
      assign diff  = trial - {1'b0, base_i};
      assign fits  = (trial >= {1'b0, base_i});
      assign quotient[AX_W-1-s] = fits;
      assign rem_chain[s+1] = fits ? diff[BYTE_W-1:0] : trial[BYTE_W-1:0];
    end
  endgenerate

  assign split_ax_o  = {quotient[BYTE_W-1:0], rem_chain[AX_W]};
  assign zero_base_o = (base_i == '0);

  logic [AX_W-1:0]   product;
  logic [BYTE_W-1:0] folded;

  assign product   = AX_W'(ax_i[AX_W-1:BYTE_W]) * AX_W'(base_i);
  assign folded    = product[BYTE_W-1:0] + ax_i[BYTE_W-1:0];
  assign fold_ax_o = {{BYTE_W{1'b0}}, folded};
endmodule

// File: rtl/decadj_unit.sv
module decadj_unit
  import decadj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [AX_W-1:0]   in_ax,
  input  logic              in_cf,
  input  logic              in_af,
  input  logic [BYTE_W-1:0] in_base,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AX_W-1:0]   out_ax,
  output logic              out_cf,
  output logic              out_af,
  output logic              out_fault
);
  logic [AX_W-1:0]   unp_add_ax, unp_sub_ax;
  logic              unp_add_flag, unp_sub_flag;
  logic [BYTE_W-1:0] pk_add_al, pk_sub_al;
  logic              pk_add_cf, pk_add_af, pk_sub_cf, pk_sub_af;
  logic [AX_W-1:0]   split_ax, fold_ax;
  logic              zero_base;
  adj_res_t          nxt;
  adj_res_t          held;
  logic              held_valid;
  logic              take;

  decadj_unpacked #(.SUBTRACT(1'b0)) u_unp_add (
    .ax_i(in_ax), .af_i(in_af), .ax_o(unp_add_ax), .flag_o(unp_add_flag));
  decadj_unpacked #(.SUBTRACT(1'b1)) u_unp_sub (
    .ax_i(in_ax), .af_i(in_af), .ax_o(unp_sub_ax), .flag_o(unp_sub_flag));

  decadj_packed #(.SUBTRACT(1'b0)) u_pk_add (
    .al_i(in_ax[BYTE_W-1:0]), .cf_i(in_cf), .af_i(in_af),
    .al_o(pk_add_al), .cf_o(pk_add_cf), .af_o(pk_add_af));
  decadj_packed #(.SUBTRACT(1'b1)) u_pk_sub (
    .al_i(in_ax[BYTE_W-1:0]), .cf_i(in_cf), .af_i(in_af),
    .al_o(pk_sub_al), .cf_o(pk_sub_cf), .af_o(pk_sub_af));

  decadj_muldiv u_muldiv (
    .ax_i(in_ax), .base_i(in_base),
    .split_ax_o(split_ax), .fold_ax_o(fold_ax), .zero_base_o(zero_base));

  always_comb begin
    nxt.ax    = in_ax;
    nxt.cf    = in_cf;
    nxt.af    = in_af;
    nxt.fault = 1'b0;
    case (in_op)
      OP_UNP_ADD: begin
        nxt.ax = unp_add_ax;
        nxt.cf = unp_add_flag;
        nxt.af = unp_add_flag;
      end
      OP_UNP_SUB: begin
        nxt.ax = unp_sub_ax;
        nxt.cf = unp_sub_flag;
        nxt.af = unp_sub_flag;
      end
      OP_PK_ADD: begin
        nxt.ax = {in_ax[AX_W-1:BYTE_W], pk_add_al};
        nxt.cf = pk_add_cf;
        nxt.af = pk_add_af;
      end
      OP_PK_SUB: begin
        nxt.ax = {in_ax[AX_W-1:BYTE_W], pk_sub_al};
        nxt.cf = pk_sub_cf;
        nxt.af = pk_sub_af;
      end
      OP_MUL_SPLIT: begin
        if (zero_base) nxt.fault = 1'b1;
        else           nxt.ax    = split_ax;
      end
      OP_DIV_FOLD: nxt.ax = fold_ax;
      default: ;
    endcase
  end

  assign in_ready = !held_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held       <= '0;
    end else begin
      if (take) begin
        held_valid <= 1'b1;
        held       <= nxt;
      end else if (out_ready) begin
        held_valid <= 1'b0;
      end
    end
  end

  assign out_valid = held_valid;
  assign out_ax    = held.ax;
  assign out_cf    = held.cf;
  assign out_af    = held.af;
  assign out_fault = held.fault;
endmodule

// File: rtl/decadj_unit_chk.sv
module decadj_unit_chk
  import decadj_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_op,
  input logic [AX_W-1:0]   in_ax,
  input logic              in_cf,
  input logic              in_af,
  input logic [BYTE_W-1:0] in_base,
  input logic              out_valid,
  input logic              out_ready,
  input logic [AX_W-1:0]   out_ax,
  input logic              out_cf,
  input logic              out_af,
  input logic              out_fault
);
  logic accept;
  assign accept = in_valid && in_ready;

  assert_result_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ax) && $stable(out_cf)
                                   && $stable(out_af) && $stable(out_fault)));

  assert_unpacked_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_op == OP_UNP_ADD || in_op == OP_UNP_SUB))
      |=> (out_ax[BYTE_W-1:NIB_W] == '0 && out_cf == out_af));

  assert_packed_keeps_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_op == OP_PK_ADD || in_op == OP_PK_SUB) && in_cf)
      |=> (out_cf && out_ax[AX_W-1:BYTE_W] == $past(in_ax[AX_W-1:BYTE_W])));

  assert_zero_base_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == OP_MUL_SPLIT && in_base == '0)
      |=> (out_fault && out_ax == $past(in_ax)));

  assert_no_stray_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(in_op == OP_MUL_SPLIT && in_base == '0)) |=> !out_fault);

  assert_fold_clears_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == OP_DIV_FOLD)
      |=> (out_ax[AX_W-1:BYTE_W] == '0 && out_cf == $past(in_cf)
           && out_af == $past(in_af)));

  assert_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op >= 3'd6)
      |=> (out_ax == $past(in_ax) && out_cf == $past(in_cf) && out_af == $past(in_af)));
endmodule

bind decadj_unit decadj_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_ax(in_ax), .in_cf(in_cf), .in_af(in_af), .in_base(in_base),
  .out_valid(out_valid), .out_ready(out_ready), .out_ax(out_ax),
  .out_cf(out_cf), .out_af(out_af), .out_fault(out_fault));

// File: tb/decadj_unit_tb.sv
module decadj_unit_tb;
  import decadj_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [OP_W-1:0]   in_op = '0;
  logic [AX_W-1:0]   in_ax = '0;
  logic              in_cf = 1'b0;
  logic              in_af = 1'b0;
  logic [BYTE_W-1:0] in_base = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [AX_W-1:0]   out_ax;
  logic              out_cf;
  logic              out_af;
  logic              out_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  adj_res_t exp_q[$];
  string    tag_q[$];

  always #2 clk = ~clk;

  decadj_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_ax(in_ax), .in_cf(in_cf), .in_af(in_af), .in_base(in_base),
    .out_valid(out_valid), .out_ready(out_ready), .out_ax(out_ax),
    .out_cf(out_cf), .out_af(out_af), .out_fault(out_fault));

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd5: return "R7";
      3'd6, 3'd7: return "R8";
      default: return "R5";
    endcase
  endfunction

  function automatic adj_res_t ref_model(logic [2:0] op, logic [15:0] ax,
                                         logic cf, logic af, logic [7:0] base);
    adj_res_t r;
    int al, ah, tot;
    r.ax = ax; r.cf = cf; r.af = af; r.fault = 1'b0;
    al = int'(ax[7:0]);
    ah = int'(ax[15:8]);
    case (op)
      3'd0: begin
        if ((al % 16) > 9 || af) begin
          tot = (ah * 256 + al + 6) % 65536;
          ah = (tot / 256 + 1) % 256;
          al = tot % 256;
          r.cf = 1'b1; r.af = 1'b1;
        end else begin
          r.cf = 1'b0; r.af = 1'b0;
        end
        r.ax = 16'(ah * 256 + (al % 16));
      end
      3'd1: begin
        if ((al % 16) > 9 || af) begin
          al = (al + 250) % 256;
          ah = (ah + 255) % 256;
          r.cf = 1'b1; r.af = 1'b1;
        end else begin
          r.cf = 1'b0; r.af = 1'b0;
        end
        r.ax = 16'(ah * 256 + (al % 16));
      end
      3'd2, 3'd3: begin
        if ((al % 16) > 9 || af) begin
          al = (op == 3'd2) ? (al + 6) % 256 : (al + 250) % 256;
          r.af = 1'b1;
        end
        if (al > 159 || cf) begin
          al = (op == 3'd2) ? (al + 96) % 256 : (al + 160) % 256;
          r.cf = 1'b1;
        end
        r.ax = 16'(ah * 256 + al);
      end
      3'd4: begin
        if (base == 8'd0) r.fault = 1'b1;
        else begin
          tot = ah * 256 + al;
          r.ax = 16'(((tot / int'(base)) % 256) * 256 + (tot % int'(base)));
        end
      end
      3'd5: r.ax = 16'((ah * int'(base) + al) % 256);
      default: ;
    endcase
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic step(bit v, logic [2:0] op, logic [15:0] ax, logic cf, logic af,
                      logic [7:0] base, bit rdy);
    bit had;
    @(negedge clk);
    had = (exp_q.size() > 0);
    check(out_valid == had, "R9", "out_valid", out_valid, had);
    if (out_valid && had) begin
      check(out_ax == exp_q[0].ax, tag_q[0], "out_ax", out_ax, exp_q[0].ax);
      check(out_cf == exp_q[0].cf && out_af == exp_q[0].af, tag_q[0], "cf,af",
            {out_cf, out_af}, {exp_q[0].cf, exp_q[0].af});
      check(out_fault == exp_q[0].fault, (tag_q[0] == "R5") ? "R6" : tag_q[0],
            "out_fault", out_fault, exp_q[0].fault);
    end
    in_valid = v; in_op = op; in_ax = ax; in_cf = cf; in_af = af; in_base = base;
    out_ready = rdy;
    #1;
    check(in_ready == (!out_valid || rdy), "R9", "in_ready", in_ready, !out_valid || rdy);
    if (out_valid && rdy && had) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (v && in_ready) begin
      exp_q.push_back(ref_model(op, ax, cf, af, base));
      tag_q.push_back((op == 3'd4 && base == 8'd0) ? "R6" : tag_of(op));
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 3; k++) step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 8'd0, 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R10", "in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 unpacked add: no fix, nibble fix, af fix, carry into AH from AX+6
    step(1, 3'd0, 16'h0307, 0, 0, 8'd10, 1);
    step(1, 3'd0, 16'h000F, 0, 0, 8'd10, 1);
    step(1, 3'd0, 16'h0112, 0, 1, 8'd10, 1);
    step(1, 3'd0, 16'h02FC, 0, 0, 8'd10, 1);
    // R2 unpacked subtract
    step(1, 3'd1, 16'h0209, 0, 1, 8'd10, 1);
    step(1, 3'd1, 16'h0005, 1, 0, 8'd10, 1);
    step(1, 3'd1, 16'h00FF, 0, 0, 8'd10, 1);
    // R3 packed add: second step sees first-step result; kept flags
    step(1, 3'd2, 16'h119A, 0, 0, 8'd10, 1);
    step(1, 3'd2, 16'h222F, 0, 0, 8'd10, 1);
    step(1, 3'd2, 16'h0045, 1, 1, 8'd10, 1);
    step(1, 3'd2, 16'h0033, 0, 0, 8'd10, 1);
    // R4 packed subtract
    step(1, 3'd3, 16'h0A0F, 0, 0, 8'd10, 1);
    step(1, 3'd3, 16'h00FA, 0, 0, 8'd10, 1);
    step(1, 3'd3, 16'h0010, 1, 1, 8'd10, 1);
    // R5 split, R6 zero base
    step(1, 3'd4, 16'h0051, 1, 0, 8'd10, 1);
    step(1, 3'd4, 16'h00FF, 0, 1, 8'd16, 1);
    step(1, 3'd4, 16'h1234, 0, 0, 8'd1, 1);
    step(1, 3'd4, 16'h1234, 1, 1, 8'd0, 1);
    // R7 fold
    step(1, 3'd5, 16'h0907, 0, 1, 8'd10, 1);
    step(1, 3'd5, 16'hFFFF, 1, 0, 8'd255, 1);
    // R8 pass-through
    step(1, 3'd6, 16'hBEEF, 1, 0, 8'd0, 1);
    step(1, 3'd7, 16'h1357, 0, 1, 8'd3, 1);
    // R9 back-pressure: stall with a pending result and a waiting request
    step(1, 3'd0, 16'h0009, 0, 0, 8'd10, 0);
    step(1, 3'd1, 16'h0304, 0, 0, 8'd10, 0);
    step(1, 3'd1, 16'h0304, 0, 0, 8'd10, 0);
    step(1, 3'd1, 16'h0304, 0, 0, 8'd10, 1);
    drain();

    for (int n = 0; n < 3000; n++) begin
      logic [2:0]  op;
      logic [15:0] ax;
      logic [7:0]  base;
      op = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) != 0)
        ax = {8'($urandom_range(0, 9)), 4'($urandom_range(0, 9)), 4'($urandom_range(0, 15))};
      else
        ax = 16'($urandom);
      base = ($urandom_range(0, 9) == 0) ? 8'd0 : 8'($urandom_range(1, 255));
      step($urandom_range(0, 9) < 7, op, ax, 1'($urandom), 1'($urandom), base,
           $urandom_range(0, 3) != 0);
    end
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule